// File: doc/BRIEF.md
# In-Band Pipelined Request Issuer

This block lets a graphics-side bus master put memory requests into a host's request queue over the shared 32-bit address/data lines. Sideband addressing is not used. A requester in front of the block offers one request at a time: a 4-bit command, an 8-byte-aligned address and a 3-bit length code. The block raises its bus request. It waits for a grant whose 3-bit status says that a new transaction may start. It then marks each address-only cycle with a request-phase strobe, driving the command on the command lines and the packed address/length word on the data lines.

Addresses at or above 4 GiB need two cycles. The first carries a dual-address command together with the low word. The second carries the real command together with the upper 32 address bits. The block keeps a count of requests issued but not yet completed. It stops issuing once that count reaches the limit that software sets at initialisation. Fences are the exception, because a fence returns no data and so takes no queue slot. Nothing is issued until the configuration enable is set. Data phases and conventional bus transactions are handled elsewhere.

Top module: `pipe_req_issuer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ask_o`, `issue_o`, `cmd_o`, `ad_o` and `cnt_o` are all zero.
- R2: While `cfg_en_i` is low, no new request is started: `ask_o` is low in the following cycle, and `issue_o` is low in the following cycle unless a dual-address sequence is already under way.
- R3: A request starts only at a clock edge where `grant_i` is high and `grant_stat_i` equals 3'b111. Any other status, including the data-phase codes 3'b0xx, or a missing grant, leaves `issue_o` low in the next cycle.
- R4: A request below 4 GiB is issued in one cycle, the cycle after the edge that accepts it. In that cycle `issue_o`=1, `cmd_o` carries the request command, `ad_o[31:3]` carries address bits 31..3 and `ad_o[2:0]` carries the length code (length = 8×(code+1) bytes). The command codes are: low-priority read 4'b0000, low-priority write 4'b0100, flush 4'b1010, fence 4'b1100.
- R5: A request whose address bits 63..32 are not all zero is issued over two consecutive cycles, both with `issue_o`=1. In the first, `cmd_o`=4'b1001 (dual address) and `ad_o` is packed as in R4. In the second, `cmd_o` is the real command and `ad_o` carries address bits 63..32. The second cycle always follows, whatever the grant.
- R6: `cnt_o` rises by one for each issued request other than a fence, and falls by one for each cycle with `done_i` high. When the count is zero, `done_i` is ignored. An issue and a completion in the same cycle leave the count unchanged.
- R7: A non-fence request is not started while `cnt_o` is at or above the limit. The limit is `cfg_max_i`, clamped to the parameter MAX_Q. A fence is started even when the count is at the limit.
- R8: While the start condition holds at every edge, single-cycle requests go out back to back with `issue_o` staying high. `issue_o` falls in the cycle after the first edge where the grant or status is lost.
- R9: `ask_o` is registered. In each cycle it equals `cfg_en_i` && `rq_valid_i` && (count below limit or the offered command is a fence), as sampled at the previous edge.
- R10: `rq_ready_o` is high in the cycle that consumes the offered request: the single issue cycle, or the second cycle of a dual-address pair. The requester holds its request stable until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_i | input | 1 | Queued requests allowed (set after initialisation) |
| cfg_max_i | input | CNT_W | Configured maximum of outstanding requests |
| grant_i | input | 1 | Bus granted to this master |
| grant_stat_i | input | 3 | Grant status; 3'b111 allows a new start |
| done_i | input | 1 | One outstanding request completed this cycle |
| rq_valid_i | input | 1 | A request is offered |
| rq_ready_o | output | 1 | Offered request consumed at this edge |
| rq_cmd_i | input | 4 | Request command code |
| rq_addr_i | input | ADDR_W-3 | Request address bits ADDR_W-1..3 |
| rq_len_i | input | 3 | Length code, 8×(code+1) bytes |
| ask_o | output | 1 | Bus request to the arbiter |
| issue_o | output | 1 | Request-phase strobe for an address-only cycle |
| cmd_o | output | 4 | Command lines |
| ad_o | output | 32 | Address/data lines during a request cycle |
| cnt_o | output | CNT_W | Outstanding request count |

## Verification
All bus-side outputs (`ask_o`, `issue_o`, `cmd_o`, `ad_o`, `cnt_o`) are registered. They reflect the inputs at an edge during the cycle after that edge. The dual-address upper word is due two cycles after the accepting edge. `rq_ready_o` is combinational and is due in the same cycle as the inputs that cause it. The bench drives its inputs on the falling edge and checks `rq_ready_o` one time step later. It then predicts the registered outputs from a model of the requirements and compares them at the next falling edge.

// File: rtl/pri_pkg.sv
package pri_pkg;
  localparam logic [3:0] CMD_RD_LO = 4'b0000;
  localparam logic [3:0] CMD_WR_LO = 4'b0100;
  localparam logic [3:0] CMD_FLUSH = 4'b1010;
  localparam logic [3:0] CMD_FENCE = 4'b1100;
  localparam logic [3:0] CMD_DUAL  = 4'b1001;

  localparam logic [2:0] STAT_MAY_START = 3'b111;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_LOW  = 2'd1,
    CYC_HIGH = 2'd2
  } cyc_sel_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/pri_depth_tracker.sv
module pri_depth_tracker #(
  parameter int MAX_Q = 8,
  parameter int CNT_W = $clog2(MAX_Q + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cfg_max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             below_lim_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_Q);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             dec;

  // clamp software limit to physical queue capacity
  assign limit       = (cfg_max_i > CAP) ? CAP : cfg_max_i;
  assign below_lim_o = (cnt_q < limit);
  assign dec         = done_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take_i && !dec) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (dec && !take_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pri_cycle_fmt.sv
module pri_cycle_fmt
  import pri_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_sel_e          sel_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:3] addr_i,
  input  logic [2:0]        len_i,
  output logic              is_hi_o,
  output logic              issue_o,
  output logic [3:0]        cmd_o,
  output logic [31:0]       ad_o
);
  logic [31:0] lo_word;
  logic [31:0] hi_word;

  assign lo_word = {addr_i[31:3], len_i};

  generate
    if (ADDR_W >= 64) begin : g_full
      assign hi_word = addr_i[63:32];
    end else begin : g_narrow
      assign hi_word = {{(64 - ADDR_W){1'b0}}, addr_i[ADDR_W-1:32]};
    end
  endgenerate

  assign is_hi_o = (hi_word != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_o <= 1'b0;
      cmd_o   <= '0;
      ad_o    <= '0;
    end else begin
      case (sel_i)
        CYC_LOW: begin
          issue_o <= 1'b1;
          cmd_o   <= cmd_i;
          ad_o    <= lo_word;
        end
        CYC_HIGH: begin
          issue_o <= 1'b1;
          cmd_o   <= cmd_i;
          ad_o    <= hi_word;
        end
        default: begin
          issue_o <= 1'b0;
          cmd_o   <= '0;
          ad_o    <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pri_issue_ctl.sv
module pri_issue_ctl
  import pri_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en_i,
  input  logic       grant_i,
  input  logic [2:0] grant_stat_i,
  input  logic       rq_valid_i,
  input  logic [3:0] rq_cmd_i,
  input  logic       rq_is_hi_i,
  input  logic       room_i,
  output cyc_sel_e   sel_o,
  output logic [3:0] cmd_sel_o,
  output logic       ready_o,
  output logic       take_o,
  output logic       ask_o
);
  phase_e phase_q, phase_d;
  logic   may_start;
  logic   go;
  logic   ask_q;

  assign may_start = grant_i && (grant_stat_i == STAT_MAY_START);
  assign go        = cfg_en_i && may_start && rq_valid_i && room_i;

  always_comb begin
    sel_o     = CYC_NONE;
    cmd_sel_o = rq_cmd_i;
    ready_o   = 1'b0;
    take_o    = 1'b0;
    phase_d   = phase_q;
    case (phase_q)
      PH_HIGH: begin
        // second half of a dual-address pair always completes
        sel_o   = CYC_HIGH;
        ready_o = 1'b1;
        take_o  = (rq_cmd_i != CMD_FENCE);
        phase_d = PH_IDLE;
      end
      default: begin
        if (go) begin
          sel_o = CYC_LOW;
          if (rq_is_hi_i) begin
            cmd_sel_o = CMD_DUAL;
            phase_d   = PH_HIGH;
          end else begin
            ready_o = 1'b1;
            take_o  = (rq_cmd_i != CMD_FENCE);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      ask_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ask_q   <= cfg_en_i && rq_valid_i && room_i;
    end
  end

  assign ask_o = ask_q;
endmodule

// File: rtl/pipe_req_issuer.sv
module pipe_req_issuer
  import pri_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MAX_Q  = 8,
  parameter int CNT_W  = $clog2(MAX_Q + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en_i,
  input  logic [CNT_W-1:0]  cfg_max_i,
  input  logic              grant_i,
  input  logic [2:0]        grant_stat_i,
  input  logic              done_i,
  input  logic              rq_valid_i,
  output logic              rq_ready_o,
  input  logic [3:0]        rq_cmd_i,
  input  logic [ADDR_W-1:3] rq_addr_i,
  input  logic [2:0]        rq_len_i,
  output logic              ask_o,
  output logic              issue_o,
  output logic [3:0]        cmd_o,
  output logic [31:0]       ad_o,
  output logic [CNT_W-1:0]  cnt_o
);
  cyc_sel_e   sel;
  logic [3:0] cmd_sel;
  logic       take;
  logic       below_lim;
  logic       room;
  logic       is_hi;

  assign room = below_lim || (rq_cmd_i == CMD_FENCE);

  pri_depth_tracker #(.MAX_Q(MAX_Q), .CNT_W(CNT_W)) u_depth (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take),
    .done_i     (done_i),
    .cfg_max_i  (cfg_max_i),
    .cnt_o      (cnt_o),
    .below_lim_o(below_lim)
  );

  pri_issue_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cfg_en_i    (cfg_en_i),
    .grant_i     (grant_i),
    .grant_stat_i(grant_stat_i),
    .rq_valid_i  (rq_valid_i),
    .rq_cmd_i    (rq_cmd_i),
    .rq_is_hi_i  (is_hi),
    .room_i      (room),
    .sel_o       (sel),
    .cmd_sel_o   (cmd_sel),
    .ready_o     (rq_ready_o),
    .take_o      (take),
    .ask_o       (ask_o)
  );

  pri_cycle_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (sel),
    .cmd_i  (cmd_sel),
    .addr_i (rq_addr_i),
    .len_i  (rq_len_i),
    .is_hi_o(is_hi),
    .issue_o(issue_o),
    .cmd_o  (cmd_o),
    .ad_o   (ad_o)
  );
endmodule

// File: rtl/pri_checker.sv
module pri_checker
  import pri_pkg::*;
#(
  parameter int MAX_Q = 8,
  parameter int CNT_W = $clog2(MAX_Q + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en_i,
  input logic             grant_i,
  input logic [2:0]       grant_stat_i,
  input logic             issue_o,
  input logic [3:0]       cmd_o,
  input logic [CNT_W-1:0] cnt_o
);
  // R5: a dual-address cycle is followed by the real command
  a_r5_dual_pair: assert property (@(posedge clk) disable iff (rst)
    (issue_o && cmd_o == CMD_DUAL) |=> (issue_o && cmd_o != CMD_DUAL));

  // R7: count never passes the physical capacity
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= CNT_W'(MAX_Q));

  // R2: nothing new starts while disabled
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en_i && !(issue_o && cmd_o == CMD_DUAL)) |=> !issue_o);

  // R3: no start without a grant carrying the start status
  a_r3_start_status: assert property (@(posedge clk) disable iff (rst)
    (!(grant_i && grant_stat_i == STAT_MAY_START) && !(issue_o && cmd_o == CMD_DUAL))
      |=> !issue_o);

  // R6: the count moves by at most one per cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1)
              || cnt_o == $past(cnt_o) - CNT_W'(1)));
endmodule

bind pipe_req_issuer pri_checker #(.MAX_Q(MAX_Q), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_en_i    (cfg_en_i),
  .grant_i     (grant_i),
  .grant_stat_i(grant_stat_i),
  .issue_o     (issue_o),
  .cmd_o       (cmd_o),
  .cnt_o       (cnt_o)
);

// File: tb/pipe_req_issuer_tb_top.sv
module pipe_req_issuer_tb_top;
  localparam int MAXQ = 8;
  localparam int CW   = 4;
  localparam logic [3:0] RD = 4'b0000, WR = 4'b0100, FL = 4'b1010, FE = 4'b1100, DU = 4'b1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic [CW-1:0] cfg_max = '0;
  logic gnt = 1'b0;
  logic [2:0] st = 3'b000;
  logic done = 1'b0;
  logic have_req = 1'b0;
  logic rdy;
  logic [3:0] cur_cmd = '0;
  logic [63:0] cur_addr = '0;
  logic [2:0] cur_len = '0;
  logic ask, issue;
  logic [3:0] cmd;
  logic [31:0] ad;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_err = 0;
  int m_cnt = 0;
  bit m_hi = 1'b0;
  bit last_acc = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  pipe_req_issuer #(.ADDR_W(64), .MAX_Q(MAXQ), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_en_i(cfg_en), .cfg_max_i(cfg_max),
    .grant_i(gnt), .grant_stat_i(st), .done_i(done),
    .rq_valid_i(have_req), .rq_ready_o(rdy), .rq_cmd_i(cur_cmd),
    .rq_addr_i(cur_addr[63:3]), .rq_len_i(cur_len),
    .ask_o(ask), .issue_o(issue), .cmd_o(cmd), .ad_o(ad), .cnt_o(cnt)
  );

  task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic bit room_f(int c, int mx, logic [3:0] k);
    int lim;
    lim = (mx > MAXQ) ? MAXQ : mx;
    return (k == FE) || (c < lim);
  endfunction

  task automatic set_req(logic [3:0] k, logic [63:0] a, logic [2:0] l);
    have_req = 1'b1; cur_cmd = k; cur_addr = a & ~64'h7; cur_len = l;
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic step();
    bit room, hi, go, acc, nhi, e_iss, e_rdy, e_ask;
    logic [3:0] e_cmd;
    logic [31:0] e_ad;
    int nc;
    room = room_f(m_cnt, int'(cfg_max), cur_cmd);
    hi = (cur_addr[63:32] != 0);
    go = !m_hi && cfg_en && gnt && (st == 3'b111) && have_req && room;
    acc = 0; nhi = 0; e_iss = 0; e_rdy = 0; e_cmd = '0; e_ad = '0;
    if (m_hi) begin
      e_iss = 1; e_cmd = cur_cmd; e_ad = cur_addr[63:32]; e_rdy = 1; acc = 1;
    end else if (go && hi) begin
      e_iss = 1; e_cmd = DU; e_ad = {cur_addr[31:3], cur_len}; nhi = 1;
    end else if (go) begin
      e_iss = 1; e_cmd = cur_cmd; e_ad = {cur_addr[31:3], cur_len}; e_rdy = 1; acc = 1;
    end
    e_ask = cfg_en && have_req && room;
    nc = m_cnt + ((acc && cur_cmd != FE) ? 1 : 0) - ((done && m_cnt != 0) ? 1 : 0);
    #1;
    chk("R10", "rq_ready", 64'(rdy), 64'(e_rdy));
    @(posedge clk);
    @(negedge clk);
    chk(tag, "issue", 64'(issue), 64'(e_iss));
    chk(tag, "cmd", 64'(cmd), 64'(e_cmd));
    chk(tag, "ad", 64'(ad), 64'(e_ad));
    chk("R9", "ask", 64'(ask), 64'(e_ask));
    chk("R6", "count", 64'(cnt), 64'(nc));
    m_cnt = nc; m_hi = nhi; last_acc = acc;
    if (acc) have_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("R1", "ask", 64'(ask), 0);
    chk("R1", "issue", 64'(issue), 0);
    chk("R1", "cmd", 64'(cmd), 0);
    chk("R1", "ad", 64'(ad), 0);
    chk("R1", "count", 64'(cnt), 0);
    rst = 1'b0;
    step();
    // R2: disabled, everything else ready
    tag = "R2";
    cfg_max = 4; gnt = 1; st = 3'b111;
    set_req(RD, 64'h0000_1000, 3'd1);
    repeat (3) step();
    // R3: data-phase status and missing grant
    tag = "R3";
    cfg_en = 1; st = 3'b010; step();
    st = 3'b001; step();
    st = 3'b111; gnt = 0; step();
    // R4: single-cycle read issued
    tag = "R4"; gnt = 1; step();
    // R5: high address write over two cycles
    tag = "R5";
    set_req(WR, 64'h0000_0003_8000_0040, 3'd5);
    step(); step();
    // R8: back-to-back then grant lost
    tag = "R8";
    for (int i = 0; i < 3; i++) begin
      set_req(FL, 64'(32'h100 * (i + 1)), 3'(i));
      step();
    end
    for (int d = 0; d < 3; d++) begin done = 1; step(); end
    done = 0;
    set_req(RD, 64'h2000, 3'd7); gnt = 0; step();
    // R7: limit of 2, fence passes, completion frees a slot
    tag = "R7";
    cfg_max = 2; gnt = 1;
    step();
    set_req(RD, 64'h3000, 3'd0); step();
    set_req(WR, 64'h3008, 3'd0); step();
    chk("R7", "blocked request still pending", 64'(have_req), 1);
    set_req(FE, 64'h0, 3'd0); step();
    set_req(RD, 64'h4000, 3'd2); done = 1; step();
    done = 0; step();
    // R6: completions down to zero, extra completion ignored
    tag = "R6";
    have_req = 0; gnt = 0;
    for (int d = 0; d < 4; d++) begin done = 1; step(); end
    done = 0;
    // constrained random
    tag = "R8";
    cfg_max = 3;
    for (int c = 0; c < 600; c++) begin
      gnt = ($urandom % 4) != 0;
      st = ($urandom % 2) ? 3'b111 : 3'($urandom % 8);
      done = ($urandom % 3) == 0;
      cfg_en = ($urandom % 20) != 0;
      if (c % 60 == 0) cfg_max = CW'($urandom % 16);
      if (!have_req && ($urandom % 3) != 0) begin
        logic [3:0] k;
        logic [63:0] a;
        case ($urandom % 4)
          0: k = RD; 1: k = WR; 2: k = FL; default: k = FE;
        endcase
        if (($urandom % 10) < 3) a = {32'($urandom | 1), 32'($urandom)};
        else a = {32'h0, 32'($urandom)};
        set_req(k, a, 3'($urandom % 8));
      end
      step();
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule